// File: doc/BRIEF.md
# ADC Window Watchdog Comparator

This block checks each finished conversion of an analog-to-digital converter against a window set by two thresholds. When a guarded sample lies strictly below the low threshold or strictly above the high threshold, a sticky status flag is set. An interrupt enable passes that flag to an interrupt line. Software clears the flag with a one-cycle clear strobe, which models a write of zero to the status bit.

The compare runs only in the cycle where the conversion-done strobe is high. It uses the raw 12-bit result, so the alignment of the data register has no effect on it. Each threshold arrives as a 16-bit value, and only its low 12 bits take part in the compare.

Three configuration bits decide which samples are guarded: a regular-group enable, an injected-group enable and a single-channel bit. With the single-channel bit clear, each enabled group is guarded on every channel. With it set, only the channel that matches a 5-bit selector is guarded, and only within the enabled groups. With both enables clear, nothing is guarded.

The flag is kept by a two-state machine. In `WD_CLEAR` the flag is low, and a guarded violation (`hit`) takes the transition CLEAR→TRIPPED. In `WD_TRIPPED` the flag is high. A clear strobe with no violation in the same cycle takes the transition TRIPPED→CLEAR. In every other case the machine stays in its current state.

Top module: `adc_window_watchdog`

## Requirements
- R1: A guarded sample whose 12-bit value is strictly below the low 12 bits of the low threshold sets `flag` at the next clock edge.
- R2: A guarded sample strictly above the low 12 bits of the high threshold sets `flag` at the next clock edge.
- R3: A sample equal to either threshold counts as inside the window and does not set `flag`.
- R4: Bits 15:12 of both threshold inputs have no effect on the compare.
- R5: Samples are compared only in a cycle where `conv_done` is 1. Data in other cycles has no effect.
- R6: With `wd_single`=0, `wd_reg_en` guards every sample with `conv_inj`=0 and `wd_inj_en` guards every sample with `conv_inj`=1.
- R7: With `wd_single`=1, a sample is guarded only when `conv_chan` equals `wd_chan` and its group is enabled as in R6.
- R8: With both `wd_reg_en` and `wd_inj_en` at 0, no sample is guarded, whatever the value of `wd_single`.
- R9: `flag` stays set until a cycle with `flag_clr`=1, after which it reads 0 at the next edge.
- R10: A violation in the same cycle as `flag_clr` keeps `flag` set.
- R11: `irq` equals `flag` AND `irq_en`.
- R12: After reset, `flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | Conversion finished this cycle |
| conv_data | input | 12 | Raw conversion result |
| conv_chan | input | 5 | Channel of the result |
| conv_inj | input | 1 | 1 = injected group, 0 = regular group |
| thr_high | input | 16 | High threshold (low 12 bits used) |
| thr_low | input | 16 | Low threshold (low 12 bits used) |
| wd_reg_en | input | 1 | Guard the regular group |
| wd_inj_en | input | 1 | Guard the injected group |
| wd_single | input | 1 | Guard only the selected channel |
| wd_chan | input | 5 | Selected channel |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear strobe for the status flag |
| flag | output | 1 | Sticky out-of-window status |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle that:
- a set flag holds until a clear strobe,
- a guarded violation always sets the flag at the next edge, even when a clear arrives with it,
- a clear with no violation drops the flag,
- the interrupt never rises without its enable,
- nothing is flagged while both enables are off.

Only the bench scenarios can show the window arithmetic itself. That covers the strict compare at exactly the threshold values, the ignored upper threshold bits, each of the four multi-channel modes and three single-channel modes against the bench's reference model, and the fact that results with the strobe low have no effect.

// File: rtl/adc_wd_pkg.sv
package adc_wd_pkg;

    typedef enum logic {
        WD_CLEAR   = 1'b0,
        WD_TRIPPED = 1'b1
    } wd_state_e;

    typedef struct packed {
        logic reg_en;
        logic inj_en;
        logic single;
    } wd_guard_cfg_t;

endpackage

// File: rtl/adc_wd_guard_sel.sv
module adc_wd_guard_sel
    import adc_wd_pkg::*;
#(
    parameter int CHAN_W = 5
) (
    input  wd_guard_cfg_t     cfg,
    input  logic [CHAN_W-1:0] sel_chan,
    input  logic [CHAN_W-1:0] smp_chan,
    input  logic              smp_inj,
    output logic              guarded
);

    logic group_on;
    logic chan_ok;

    always_comb begin
        group_on = smp_inj ? cfg.inj_en : cfg.reg_en;
        chan_ok  = !cfg.single || (smp_chan == sel_chan);
        guarded  = group_on && chan_ok;
    end

endmodule

// File: rtl/adc_wd_window_cmp.sv
module adc_wd_window_cmp #(
    parameter int DATA_W = 12,
    parameter int THR_W  = 16
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [THR_W-1:0]  hi_thr,
    input  logic [THR_W-1:0]  lo_thr,
    output logic              outside
);

    localparam int PAD_W = THR_W - DATA_W;

    logic [DATA_W-1:0] hi_cut;
    logic [DATA_W-1:0] lo_cut;
    logic [2*PAD_W-1:0] unused_thr_pad;

    assign hi_cut         = hi_thr[DATA_W-1:0];
    assign lo_cut         = lo_thr[DATA_W-1:0];
    assign unused_thr_pad = {hi_thr[THR_W-1:DATA_W], lo_thr[THR_W-1:DATA_W]};

    always_comb begin
        outside = (sample < lo_cut) || (sample > hi_cut);
    end

endmodule

// File: rtl/adc_wd_flag_fsm.sv
module adc_wd_flag_fsm
    import adc_wd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);

    wd_state_e state_q;
    wd_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_CLEAR:   if (hit)         state_d = WD_TRIPPED;
            WD_TRIPPED: if (clr && !hit) state_d = WD_CLEAR;
            default:                     state_d = WD_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == WD_TRIPPED);
    end

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R10
    hit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R9
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);

endmodule

// File: rtl/adc_window_watchdog.sv
module adc_window_watchdog
    import adc_wd_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int THR_W  = 16,
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_inj,
    input  logic [THR_W-1:0]  thr_high,
    input  logic [THR_W-1:0]  thr_low,
    input  logic              wd_reg_en,
    input  logic              wd_inj_en,
    input  logic              wd_single,
    input  logic [CHAN_W-1:0] wd_chan,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              flag,
    output logic              irq
);

    wd_guard_cfg_t cfg;
    logic          guarded;
    logic          outside;
    logic          hit;

    assign cfg = '{reg_en: wd_reg_en, inj_en: wd_inj_en, single: wd_single};

    adc_wd_guard_sel #(.CHAN_W(CHAN_W)) u_sel (
        .cfg      (cfg),
        .sel_chan (wd_chan),
        .smp_chan (conv_chan),
        .smp_inj  (conv_inj),
        .guarded  (guarded)
    );

    adc_wd_window_cmp #(.DATA_W(DATA_W), .THR_W(THR_W)) u_cmp (
        .sample  (conv_data),
        .hi_thr  (thr_high),
        .lo_thr  (thr_low),
        .outside (outside)
    );

    assign hit = conv_done && guarded && outside;

    adc_wd_flag_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .clr   (flag_clr),
        .flag  (flag)
    );

    assign irq = flag && irq_en;

    // R8
    no_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_reg_en && !wd_inj_en && !flag) |=> !flag);

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);

endmodule

// File: tb/adc_window_watchdog_bench.sv
`timescale 1ns/1ps
module adc_window_watchdog_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic [4:0]  conv_chan = '0;
    logic        conv_inj = 1'b0;
    logic [15:0] thr_high = '0;
    logic [15:0] thr_low = '0;
    logic        wd_reg_en = 1'b0;
    logic        wd_inj_en = 1'b0;
    logic        wd_single = 1'b0;
    logic [4:0]  wd_chan = '0;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        flag;
    logic        irq;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R12";
    bit    ref_flag = 1'b0;

    always #5 clk = ~clk;

    adc_window_watchdog u_adc_window_watchdog (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .conv_chan(conv_chan), .conv_inj(conv_inj), .thr_high(thr_high),
        .thr_low(thr_low), .wd_reg_en(wd_reg_en), .wd_inj_en(wd_inj_en),
        .wd_single(wd_single), .wd_chan(wd_chan), .irq_en(irq_en),
        .flag_clr(flag_clr), .flag(flag), .irq(irq)
    );

    function automatic bit ref_guard();
        if (!wd_reg_en && !wd_inj_en) return 1'b0;
        if (conv_inj && !wd_inj_en) return 1'b0;
        if (!conv_inj && !wd_reg_en) return 1'b0;
        if (wd_single && conv_chan != wd_chan) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit ref_violation();
        int v, lo, hi;
        v  = conv_data;
        lo = thr_low % 4096;
        hi = thr_high % 4096;
        return (v < lo) || (v > hi);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_flag <= 1'b0;
        else begin
            if (conv_done && ref_guard() && ref_violation()) ref_flag <= 1'b1;
            else if (flag_clr) ref_flag <= 1'b0;
        end
    end

    task automatic compare();
        bit exp_irq;
        exp_irq = ref_flag && irq_en;
        checks++;
        if (flag !== ref_flag || irq !== exp_irq) begin
            failures++;
            $display("FAIL %s flag=%0b irq=%0b expected flag=%0b irq=%0b",
                     cur_req, flag, irq, ref_flag, exp_irq);
        end
    endtask

    always @(negedge clk) if (rst_n) compare();

    task automatic sample(input string req, input bit done, input int data,
                          input int chan, input bit inj);
        @(negedge clk);
        #1;
        cur_req   = req;
        conv_done = done;
        conv_data = data[11:0];
        conv_chan = chan[4:0];
        conv_inj  = inj;
        flag_clr  = 1'b0;
        @(negedge clk);
        #1;
        conv_done = 1'b0;
    endtask

    task automatic clear_flag(input string req);
        @(negedge clk);
        #1;
        cur_req  = req;
        flag_clr = 1'b1;
        @(negedge clk);
        #1;
        flag_clr = 1'b0;
    endtask

    task automatic mode(input bit r, input bit j, input bit s, input int ch);
        clear_flag("R9");
        wd_reg_en = r;
        wd_inj_en = j;
        wd_single = s;
        wd_chan   = ch[4:0];
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired flag=%0b expected run end", flag);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        thr_high = 16'hF0C8;
        thr_low  = 16'hA064;
        irq_en   = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (flag !== 1'b0 || irq !== 1'b0) begin
            failures++;
            $display("FAIL R12 flag=%0b irq=%0b expected flag=0 irq=0", flag, irq);
        end
        #1 rst_n = 1'b1;
        mode(1, 0, 0, 0);
        sample("R4", 1, 150, 3, 0);
        sample("R3", 1, 200, 3, 0);
        sample("R3", 1, 100, 3, 0);
        sample("R5", 0, 4000, 3, 0);
        sample("R1", 1, 99, 3, 0);
        sample("R9", 0, 0, 3, 0);
        sample("R9", 0, 0, 3, 0);
        clear_flag("R9");
        sample("R2", 1, 201, 7, 0);
        irq_en = 1'b0;
        sample("R11", 0, 0, 0, 0);
        irq_en = 1'b1;
        @(negedge clk);
        #1;
        cur_req   = "R10";
        conv_done = 1'b1;
        conv_data = 12'd5;
        flag_clr  = 1'b1;
        @(negedge clk);
        #1;
        conv_done = 1'b0;
        flag_clr  = 1'b0;
        mode(1, 0, 0, 0);
        sample("R6", 1, 4000, 1, 1);
        mode(0, 1, 0, 0);
        sample("R6", 1, 4000, 1, 0);
        sample("R6", 1, 4000, 1, 1);
        mode(1, 1, 0, 0);
        sample("R6", 1, 0, 9, 0);
        mode(1, 1, 0, 0);
        sample("R6", 1, 0, 9, 1);
        for (int s = 0; s < 2; s++) begin
            mode(0, 0, s[0], 4);
            sample("R8", 1, 4095, 4, 0);
            sample("R8", 1, 0, 4, 1);
        end
        for (int g = 1; g < 4; g++) begin
            mode(g[0], g[1], 1, 12);
            sample("R7", 1, 4095, 11, 0);
            sample("R7", 1, 4095, 11, 1);
            sample("R7", 1, 4095, 12, 0);
            mode(g[0], g[1], 1, 12);
            sample("R7", 1, 0, 12, 1);
        end
        clear_flag("R9");
        repeat (2) @(negedge clk);
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule